// File: doc/BRIEF.md
# Command-Stepped Vector Sequencer Beside a Memory Bank

This block is a small compute unit that sits next to one memory bank and runs a short stored program of up to 32 instruction words. It has no clock-driven fetch. The program counter moves only when the memory controller sends a column read or write command. Each command runs exactly one instruction. The data word carried by that command (256 bits, 16 lanes of 16 bits) is the operand source for instructions that read the bus.

The host first writes the program through a load port. It then enables compute mode and issues a stream of read and write commands. Write commands bring vectors and scalars into the unit's register files. Intermediate commands drive saturating fixed-point lane arithmetic. Read commands carrying a MOV instruction return a register onto the output bus. A loop instruction with a per-slot iteration counter lets a short program cover many commands. An exit instruction freezes the unit until the next program load. When several units share the same command stream in compute mode, they step in lockstep because their behaviour depends only on the commands they see.

Top module: `bank_simd_seq`

## Requirements
- R1: After reset, pc_o is 0, done_o is 0, out_vld_o is 0 and out_data_o is all zero.
- R2: The unit executes one instruction when pim_en_i=1, done_o=0, ld_we_i=0 and cmd_vld_i=1 at a rising edge.
  - The instruction executed is the word in slot pc_o.
  - Its effects, including pc_o and the outputs, appear after that same edge.
  - In a cycle without a command, nothing changes and out_vld_o is 0.
  - Instruction word fields:
    - opcode in [31:28]: NOP 0, JUMP 1, EXIT 2, MOV 3, FILL 4, ADD 5, MUL 6, MAC 7, MAD 8
    - flag X in [27], flag S in [26], reserved bits in [25:24]
    - dst in [23:20], srcA in [19:16], srcB in [15:12], scalar index in [11:8]
  - Lane l of every 256-bit word is bits [16l+15:16l].
- R3: While pim_en_i=0, commands have no effect: pc_o does not move and out_vld_o stays 0.
- R4: FILL with X=0 stores the command's bank_data_i word in GRF[dst]. FILL with X=1 stores lane l of bank_data_i in scalar entry l, for every l.
- R5: MOV copies GRF[srcA] into GRF[dst].
  - With X=1, negative lanes are replaced by 0.
  - On a read command (cmd_wr_i=0), the same value also appears on out_data_o, with out_vld_o high for one cycle.
  - On a write command, out_vld_o stays 0.
- R6: ADD writes the lane-wise signed sum, saturated to [-32768, 32767], into GRF[dst].
  - Operand A is the bank_data_i lane when X=1, otherwise GRF[srcA].
  - Operand B is scalar[index] broadcast to all lanes when S=1, otherwise GRF[srcB].
- R7: MUL writes sat((A*B) >>> 8) into GRF[dst]. This is Q8.8, with the arithmetic right shift rounding toward minus infinity. Operands are chosen as in R6.
- R8: MAC writes sat(GRF[dst] + ((A*B) >>> 8)). There is no saturation of the intermediate product.
- R9: MAD writes sat(((A*scalar[index]) >>> 8) + GRF[srcB]) into GRF[dst]. The S flag is not used.
- R10: JUMP carries its target slot in [20:16] and a count N in [11:0].
  - While the loop counter of that slot is below N, JUMP branches to the target and increments the counter.
  - Otherwise it falls through to the next slot and clears the counter.
  - So the loop body runs N+1 times on every entry.
- R11: EXIT raises done_o, and all later commands are ignored.
  - Any load write (ld_we_i) stores ld_word_i in slot ld_slot_i, sets pc_o to 0, clears done_o and clears every loop counter.
  - Register contents are kept across a load.
- R12: NOP, opcodes 9 to 15, and any word with non-zero reserved bits only advance pc_o. pc_o wraps from 31 to 0.
- R13: A load write in the same cycle as a command takes priority, and the command is not executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pim_en_i | input | 1 | Compute mode; 0 makes the unit ignore commands |
| ld_we_i | input | 1 | Program slot write strobe |
| ld_slot_i | input | 5 | Program slot written |
| ld_word_i | input | 32 | Instruction word written |
| cmd_vld_i | input | 1 | Bank column command present this cycle |
| cmd_wr_i | input | 1 | 1 = write command, 0 = read command |
| bank_data_i | input | 256 | Column data carried with the command |
| out_data_o | output | 256 | Vector returned by MOV on a read command |
| out_vld_o | output | 1 | out_data_o was updated by the last command |
| pc_o | output | 5 | Slot executed by the next command |
| done_o | output | 1 | Program has reached EXIT |

## Verification
The bench sweeps the arithmetic over lanes holding the extreme values and pseudo-random values, so that positive and negative saturation and the floor of the Q8.8 shift on negative products are all reached. A design that wrapped instead of clamping, or that truncated toward zero, would return wrong lanes at these points. Loop control is run with two nested re-entries of the same loop. If a design failed to clear the slot counter on fall-through, the second pass would skip iterations and the returned totals would drift. The bench also covers reserved-bit words, pc wrap-around, disabled mode, freezing after exit and a load colliding with a command; in each case an erroneous design would advance pc_o or pulse out_vld_o where it must not.

// File: rtl/bank_simd_seq_pkg.sv
package bank_simd_seq_pkg;

    localparam int INSTR_W = 32;
    localparam int CRF_N   = 32;
    localparam int PC_W    = $clog2(CRF_N);
    localparam int IDX_W   = 4;
    localparam int GRF_N   = 1 << IDX_W;
    localparam int JCNT_W  = 12;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_JUMP = 4'd1,
        OP_EXIT = 4'd2,
        OP_MOV  = 4'd3,
        OP_FILL = 4'd4,
        OP_ADD  = 4'd5,
        OP_MUL  = 4'd6,
        OP_MAC  = 4'd7,
        OP_MAD  = 4'd8
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              fx;
        logic              fs;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  sa;
        logic [IDX_W-1:0]  sb;
        logic [IDX_W-1:0]  si;
        logic [PC_W-1:0]   jtgt;
        logic [JCNT_W-1:0] jcnt;
    } dec_t;

endpackage

// File: rtl/bank_simd_seq_decode.sv
module bank_simd_seq_decode
    import bank_simd_seq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);

    always_comb begin
        dec_o.op   = OP_NOP;
        dec_o.fx   = instr_i[27];
        dec_o.fs   = instr_i[26];
        dec_o.dst  = instr_i[23:20];
        dec_o.sa   = instr_i[19:16];
        dec_o.sb   = instr_i[15:12];
        dec_o.si   = instr_i[11:8];
        dec_o.jtgt = instr_i[20:16];
        dec_o.jcnt = instr_i[11:0];
        // reserved bits set, or an undefined opcode, degrade to NOP
        if (instr_i[25:24] == 2'b00 && instr_i[31:28] <= 4'd8) begin
            dec_o.op = op_e'(instr_i[31:28]);
        end
    end

endmodule

// File: rtl/bank_simd_seq_lane.sv
module bank_simd_seq_lane
    import bank_simd_seq_pkg::*;
#(
    parameter int EW   = 16,
    parameter int FRAC = 8
) (
    input  op_e           op_i,
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    input  logic [EW-1:0] c_i,
    output logic [EW-1:0] y_o
);

    localparam int WW = 2 * EW + 1;
    localparam logic signed [WW-1:0] MAXV = {{(WW-EW+1){1'b0}}, {(EW-1){1'b1}}};
    localparam logic signed [WW-1:0] MINV = {{(WW-EW+1){1'b1}}, {(EW-1){1'b0}}};

    logic signed [WW-1:0] a_w, b_w, c_w, prod_w, prod_sh, sum_w;

    always_comb begin
        a_w     = {{(WW-EW){a_i[EW-1]}}, a_i};
        b_w     = {{(WW-EW){b_i[EW-1]}}, b_i};
        c_w     = {{(WW-EW){c_i[EW-1]}}, c_i};
        prod_w  = a_w * b_w;
        prod_sh = prod_w >>> FRAC;
        case (op_i)
            OP_ADD:         sum_w = a_w + b_w;
            OP_MUL:         sum_w = prod_sh;
            OP_MAC, OP_MAD: sum_w = prod_sh + c_w;
            default:        sum_w = a_w;
        endcase
        if (sum_w > MAXV) begin
            y_o = MAXV[EW-1:0];
        end else if (sum_w < MINV) begin
            y_o = MINV[EW-1:0];
        end else begin
            y_o = sum_w[EW-1:0];
        end
    end

endmodule

// File: rtl/bank_simd_seq.sv
module bank_simd_seq
    import bank_simd_seq_pkg::*;
#(
    parameter int LANES = 16,
    parameter int EW    = 16,
    parameter int FRAC  = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   pim_en_i,
    input  logic                   ld_we_i,
    input  logic [PC_W-1:0]        ld_slot_i,
    input  logic [INSTR_W-1:0]     ld_word_i,
    input  logic                   cmd_vld_i,
    input  logic                   cmd_wr_i,
    input  logic [LANES*EW-1:0]    bank_data_i,
    output logic [LANES*EW-1:0]    out_data_o,
    output logic                   out_vld_o,
    output logic [PC_W-1:0]        pc_o,
    output logic                   done_o
);

    localparam int BUS_W = LANES * EW;

    typedef struct packed {
        logic [CRF_N-1:0][INSTR_W-1:0] crf;
        logic [GRF_N-1:0][BUS_W-1:0]   grf;
        logic [LANES-1:0][EW-1:0]      srf;
        logic [CRF_N-1:0][JCNT_W-1:0]  cnt;
        logic [PC_W-1:0]               pc;
        logic                          done;
        logic [BUS_W-1:0]              q;
        logic                          qv;
    } st_t;

    st_t  st_d, st_q;
    dec_t dec;
    logic [BUS_W-1:0] alu_y;
    logic [BUS_W-1:0] mov_y;

    bank_simd_seq_decode u_dec (
        .instr_i (st_q.crf[st_q.pc]),
        .dec_o   (dec)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [EW-1:0] a_l, b_l, c_l, y_l, src_l;
        assign a_l   = dec.fx ? bank_data_i[l*EW +: EW] : st_q.grf[dec.sa][l*EW +: EW];
        assign b_l   = (dec.fs || dec.op == OP_MAD) ? st_q.srf[dec.si]
                                                    : st_q.grf[dec.sb][l*EW +: EW];
        assign c_l   = (dec.op == OP_MAC) ? st_q.grf[dec.dst][l*EW +: EW]
                                          : st_q.grf[dec.sb][l*EW +: EW];
        assign src_l = st_q.grf[dec.sa][l*EW +: EW];

        bank_simd_seq_lane #(.EW(EW), .FRAC(FRAC)) u_lane (
            .op_i (dec.op),
            .a_i  (a_l),
            .b_i  (b_l),
            .c_i  (c_l),
            .y_o  (y_l)
        );

        assign alu_y[l*EW +: EW] = y_l;
        assign mov_y[l*EW +: EW] = (dec.fx && src_l[EW-1]) ? '0 : src_l;
    end

    always_comb begin
        st_d    = st_q;
        st_d.qv = 1'b0;
        if (ld_we_i) begin
            st_d.crf[ld_slot_i] = ld_word_i;
            st_d.pc             = '0;
            st_d.done           = 1'b0;
            st_d.cnt            = '0;
        end else if (cmd_vld_i && pim_en_i && !st_q.done) begin
            st_d.pc = st_q.pc + PC_W'(1);
            case (dec.op)
                OP_JUMP: begin
                    if (st_q.cnt[st_q.pc] < dec.jcnt) begin
                        st_d.cnt[st_q.pc] = st_q.cnt[st_q.pc] + JCNT_W'(1);
                        st_d.pc           = dec.jtgt;
                    end else begin
                        st_d.cnt[st_q.pc] = '0;
                    end
                end
                OP_EXIT: begin
                    st_d.pc   = st_q.pc;
                    st_d.done = 1'b1;
                end
                OP_MOV: begin
                    st_d.grf[dec.dst] = mov_y;
                    if (!cmd_wr_i) begin
                        st_d.q  = mov_y;
                        st_d.qv = 1'b1;
                    end
                end
                OP_FILL: begin
                    if (dec.fx) begin
                        st_d.srf = bank_data_i;
                    end else begin
                        st_d.grf[dec.dst] = bank_data_i;
                    end
                end
                OP_ADD, OP_MUL, OP_MAC, OP_MAD: begin
                    st_d.grf[dec.dst] = alu_y;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data_o = st_q.q;
    assign out_vld_o  = st_q.qv;
    assign pc_o       = st_q.pc;
    assign done_o     = st_q.done;

endmodule

// File: rtl/bank_simd_seq_chk.sv
module bank_simd_seq_chk #(
    parameter int DW = 256
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          pim_en_i,
    input logic          ld_we_i,
    input logic          cmd_vld_i,
    input logic          cmd_wr_i,
    input logic [DW-1:0] out_data_o,
    input logic          out_vld_o,
    input logic [4:0]    pc_o,
    input logic          done_o
);

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmd_vld_i && !ld_we_i) |=> ($stable(pc_o) && $stable(out_data_o) && !out_vld_o));

    assert_disabled_ignores_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pim_en_i && !ld_we_i) |=> ($stable(pc_o) && !out_vld_o));

    assert_valid_from_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld_o |-> $past(cmd_vld_i && !cmd_wr_i && pim_en_i && !ld_we_i));

    assert_done_freezes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !ld_we_i) |=> (done_o && $stable(pc_o) && !out_vld_o));

    assert_load_restarts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_we_i |=> (pc_o == 5'd0 && !done_o));

    assert_load_wins_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_we_i && cmd_vld_i) |=> !out_vld_o);

endmodule

bind bank_simd_seq bank_simd_seq_chk #(.DW(BUS_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pim_en_i   (pim_en_i),
    .ld_we_i    (ld_we_i),
    .cmd_vld_i  (cmd_vld_i),
    .cmd_wr_i   (cmd_wr_i),
    .out_data_o (out_data_o),
    .out_vld_o  (out_vld_o),
    .pc_o       (pc_o),
    .done_o     (done_o)
);

// File: tb/bank_simd_seq_tb_top.sv
module bank_simd_seq_tb_top;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         pim_en_i = 1'b0;
    logic         ld_we_i = 1'b0;
    logic [4:0]   ld_slot_i = '0;
    logic [31:0]  ld_word_i = '0;
    logic         cmd_vld_i = 1'b0;
    logic         cmd_wr_i = 1'b0;
    logic [255:0] bank_data_i = '0;
    logic [255:0] out_data_o;
    logic         out_vld_o;
    logic [4:0]   pc_o;
    logic         done_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk_i = ~clk_i;

    bank_simd_seq dut_i (
        .clk_i, .rst_ni, .pim_en_i, .ld_we_i, .ld_slot_i, .ld_word_i,
        .cmd_vld_i, .cmd_wr_i, .bank_data_i, .out_data_o, .out_vld_o,
        .pc_o, .done_o
    );

    function automatic logic [31:0] enc(int op, int x, int s, int d, int a, int b, int si);
        return {4'(op), 1'(x), 1'(s), 2'b00, 4'(d), 4'(a), 4'(b), 4'(si), 8'h00};
    endfunction

    function automatic logic [31:0] jmp(int tgt, int cnt);
        return {4'd1, 7'd0, 5'(tgt), 4'd0, 12'(cnt)};
    endfunction

    function automatic int lane(logic [255:0] w, int l);
        return int'($signed(w[l*16 +: 16]));
    endfunction

    function automatic logic [15:0] sat(int v);
        if (v > 32767) return 16'h7fff;
        if (v < -32768) return 16'h8000;
        return 16'(v);
    endfunction

    function automatic logic [255:0] splat(int v);
        logic [255:0] r;
        for (int l = 0; l < 16; l++) r[l*16 +: 16] = 16'(v);
        return r;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic load(int slot, logic [31:0] w);
        @(negedge clk_i);
        ld_we_i = 1'b1; ld_slot_i = 5'(slot); ld_word_i = w;
        @(negedge clk_i);
        ld_we_i = 1'b0;
    endtask

    task automatic cmd(bit wr, logic [255:0] d);
        @(negedge clk_i);
        cmd_vld_i = 1'b1; cmd_wr_i = wr; bank_data_i = d;
        @(negedge clk_i);
        cmd_vld_i = 1'b0;
    endtask

    task automatic load_p1();
        load(0, enc(4,0,0,0,0,0,0));
        load(1, enc(4,0,0,1,0,0,0));
        load(2, enc(4,1,0,0,0,0,0));
        load(3, enc(5,0,0,2,0,1,0));
        load(4, enc(3,0,0,4,2,0,0));
        load(5, enc(6,0,0,3,0,1,0));
        load(6, enc(3,0,0,5,3,0,0));
        load(7, enc(5,1,1,6,0,0,3));
        load(8, enc(3,0,0,10,6,0,0));
        load(9, enc(7,0,0,3,0,1,0));
        load(10, enc(3,0,0,11,3,0,0));
        load(11, enc(8,0,0,7,0,1,5));
        load(12, enc(3,0,0,12,7,0,0));
        load(13, enc(3,1,0,8,0,0,0));
        load(14, enc(3,0,0,9,0,0,0));
        load(15, enc(2,0,0,0,0,0,0));
        for (int s = 16; s < 32; s++) load(s, 32'h0);
    endtask

    logic [255:0] va, vb, vs, vc, e_add, e_mul, e_bus, e_mac, e_mad, e_relu;
    int seed = 12345;

    function automatic logic [15:0] pick(int p, int k);
        if (p == 0) return (k % 2) ? 16'h7fff : 16'h8000;
        if (p == 1) return (k % 3 == 0) ? 16'h8000 : ((k % 3 == 1) ? 16'h7fff : 16'h0100);
        return 16'h0;
    endfunction

    initial begin
        int nv;
        repeat (3) @(negedge clk_i);
        check("R1 pc", 256'(pc_o), 256'd0);
        check("R1 done", 256'(done_o), 256'd0);
        check("R1 vld", 256'(out_vld_o), 256'd0);
        check("R1 data", out_data_o, 256'd0);
        rst_ni = 1'b1;
        pim_en_i = 1'b1;

        // arithmetic sweep
        for (int p = 0; p < 24; p++) begin
            for (int l = 0; l < 16; l++) begin
                if (p < 2) begin
                    va[l*16 +: 16] = pick(p, l);
                    vb[l*16 +: 16] = pick(p, l + 1);
                    vs[l*16 +: 16] = pick(p, l + 2);
                    vc[l*16 +: 16] = pick(p, l);
                end else begin
                    seed = seed * 1103515245 + 12345; va[l*16 +: 16] = 16'(seed >>> 9);
                    seed = seed * 1103515245 + 12345; vb[l*16 +: 16] = 16'(seed >>> 9);
                    seed = seed * 1103515245 + 12345; vs[l*16 +: 16] = 16'(seed >>> 9);
                    seed = seed * 1103515245 + 12345; vc[l*16 +: 16] = 16'(seed >>> 9);
                end
            end
            for (int l = 0; l < 16; l++) begin
                int a, b, m;
                a = lane(va, l); b = lane(vb, l);
                e_add[l*16 +: 16] = sat(a + b);
                m = int'($signed(sat((a * b) >>> 8)));
                e_mul[l*16 +: 16] = 16'(m);
                e_bus[l*16 +: 16] = sat(lane(vc, l) + lane(vs, 3));
                e_mac[l*16 +: 16] = sat(m + ((a * b) >>> 8));
                e_mad[l*16 +: 16] = sat(((a * lane(vs, 5)) >>> 8) + b);
                e_relu[l*16 +: 16] = (a < 0) ? 16'h0 : 16'(a);
            end
            load_p1();
            check("R11 reload clears done", 256'(done_o), 256'd0);
            cmd(1, va); check("R2 step", 256'(pc_o), 256'd1);
            cmd(1, vb);
            cmd(1, vs);
            cmd(0, '0); check("R5 no pulse on ADD", 256'(out_vld_o), 256'd0);
            cmd(0, '0); check("R5 vld", 256'(out_vld_o), 256'd1);
            check("R6 add", out_data_o, e_add);
            cmd(0, '0); cmd(0, '0); check("R7 mul", out_data_o, e_mul);
            cmd(1, vc); cmd(0, '0); check("R6/R4 bus plus scalar", out_data_o, e_bus);
            cmd(0, '0); cmd(0, '0); check("R8 mac", out_data_o, e_mac);
            cmd(0, '0); cmd(0, '0); check("R9 mad", out_data_o, e_mad);
            cmd(0, '0); check("R5 relu", out_data_o, e_relu);
            cmd(1, '0); check("R5 write mov no pulse", 256'(out_vld_o), 256'd0);
            cmd(0, '0); check("R11 exit done", 256'(done_o), 256'd1);
            cmd(0, '0); check("R11 frozen vld", 256'(out_vld_o), 256'd0);
            check("R11 frozen pc", 256'(pc_o), 256'd15);
        end

        // control program
        load(0, enc(4,0,0,1,0,0,0));
        load(1, enc(4,0,0,2,0,0,0));
        load(2, enc(5,0,0,1,1,2,0));
        load(3, jmp(2, 4));
        load(4, enc(3,0,0,3,1,0,0));
        load(5, jmp(2, 2));
        load(6, enc(5,0,0,1,1,2,0) | 32'h0100_0000);
        load(7, enc(3,0,0,3,1,0,0));
        for (int s = 8; s < 32; s++) load(s, 32'h0);

        pim_en_i = 1'b0;
        repeat (3) cmd(0, '0);
        check("R3 disabled pc", 256'(pc_o), 256'd0);
        check("R3 disabled vld", 256'(out_vld_o), 256'd0);
        pim_en_i = 1'b1;
        repeat (4) @(negedge clk_i);
        check("R2 idle pc", 256'(pc_o), 256'd0);

        nv = 0;
        for (int k = 1; k <= 64; k++) begin
            if (k == 1) cmd(1, splat(0));
            else if (k == 2) cmd(1, splat(1));
            else cmd(0, '0);
            if (out_vld_o) begin
                nv++;
                check("R10 loop total", out_data_o, splat(nv < 4 ? 5 * nv : 15));
            end
            if (k == 12) check("R10 fall through", 256'(pc_o), 256'd4);
            if (k == 40) check("R12 reserved bits nop", 256'(pc_o), 256'd8);
        end
        check("R10 pulse count", 256'(nv), 256'd4);
        check("R12 wrap", 256'(pc_o), 256'd0);

        // load collides with command
        @(negedge clk_i);
        ld_we_i = 1'b1; ld_slot_i = 5'd0; ld_word_i = enc(3,0,0,3,1,0,0);
        cmd_vld_i = 1'b1; cmd_wr_i = 1'b0;
        @(negedge clk_i);
        ld_we_i = 1'b0; cmd_vld_i = 1'b0;
        check("R13 no execute", 256'(out_vld_o), 256'd0);
        check("R13 pc", 256'(pc_o), 256'd0);
        cmd(0, '0);
        check("R13 then runs", out_data_o, splat(15));
        check("R13 pc after", 256'(pc_o), 256'd1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule